// File: doc/BRIEF.md
# Row-Column Organized Single-Bit RAM

This block is a small memory of single-bit cells, kept as a square grid of rows and columns instead of a flat list of words. The address is split into two fields. The high field goes to a row decoder, which enables exactly one row. The low field goes to a column selector. On a write, the selector steers the input bit into one column of the enabled row. On a read, the whole enabled row is copied into a row buffer, and a column multiplexer picks one bit of that buffer for output.

The active-low chip select gates every access. The active-low write enable picks a store when it is low and a fetch when it is high. The bidirectional data line of a real part is modelled as a separate input bit, output bit and output-enable flag. The output-enable flag rises only for the cycle after a selected fetch, which is when a pad driver would be switched on. Writes and the row buffer are both registered, so read data comes out one clock after the fetch is sampled.

Top module: `bitram_rowcol`

## Requirements
- R1: The address splits with the row in the upper ROW_BITS bits and the column in the lower COL_BITS bits. With the default 3+3, address = 8*row + col, and each of the 64 addresses reaches its own cell.
- R2: On a clock edge where chipSelN=0 and writeEnN=0, the cell at the address takes dataIn. No other cell changes.
- R3: On a clock edge where chipSelN=0 and writeEnN=1, the addressed row is latched. In the following cycle, dataOut equals the stored bit of the addressed cell.
- R4: dataOutEn is 1 in exactly the cycles that follow a clock edge sampling a selected read, and 0 in all other cycles.
- R5: On a clock edge where chipSelN=1, no cell changes, whatever writeEnN and dataIn are. In the next cycle dataOutEn is 0 and dataOut keeps its previous value.
- R6: While rstN is low, every cell, the row buffer and the column register are cleared. As a result dataOut=0 and dataOutEn=0, and a later read of any cell returns 0.
- R7: A selected write leaves the row buffer alone. In the next cycle dataOutEn is 0 and dataOut keeps its previous value.
- R8: Selected reads on consecutive cycles each return their own cell's value, one per cycle, with dataOutEn held at 1.
- R9: A read issued in the cycle right after a write to the same cell returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ROW_BITS+COL_BITS | Cell address: row field high, column field low |
| chipSelN | input | 1 | Active-low chip select |
| writeEnN | input | 1 | Active-low write enable; high means read |
| dataIn | input | 1 | Bit to store on a selected write |
| dataOut | output | 1 | Bit taken from the row buffer by the column multiplexer |
| dataOutEn | output | 1 | High when dataOut would drive the shared data line |

## Verification
Some rules can be checked every cycle from the ports alone, and the bound checker covers those. The output-enable flag must follow a selected read exactly one cycle later, and in no other cycle. After a deselected cycle or a write cycle, the enable must be low and the output must not move. Whether the right cell was stored or fetched cannot be seen from one cycle at the ports, so the bench handles it with a reference model of the array. It checks that writes reach only the addressed cell, that decoding gives all 64 addresses distinct cells, that accesses are ignored while chip select is high, that back-to-back reads and read-after-write return the right values, and that a mid-run reset clears every cell.

// File: rtl/bitram_pkg.sv
package bitram_pkg;
  // strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic storeBit;  // commit dataIn into the addressed cell
    logic fetchRow;  // copy the addressed row into the row buffer
  } ramStrobe_t;
endpackage

// File: rtl/bitram_ctrl.sv
module bitram_ctrl
  import bitram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipSelN,
  input  logic       writeEnN,
  output ramStrobe_t strobe,
  output logic       readValid
);
  logic selected;

  assign selected        = ~chipSelN;
  assign strobe.storeBit = selected & ~writeEnN;
  assign strobe.fetchRow = selected & writeEnN;

  // the output driver is enabled for the cycle after a fetch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readValid <= 1'b0;
    else       readValid <= strobe.fetchRow;
  end
endmodule

// File: rtl/bitram_array.sv
module bitram_array
  import bitram_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ramStrobe_t          strobe,
  input  logic [ROW_BITS-1:0] rowAddr,
  input  logic [COL_BITS-1:0] colAddr,
  input  logic                dataIn,
  output logic                dataOut
);
  localparam int ROWS = 1 << ROW_BITS;
  localparam int COLS = 1 << COL_BITS;

  logic [ROWS-1:0] rowHit;     // row decoder output, one-hot
  logic [COLS-1:0] colHit;     // column demultiplexer select, one-hot
  logic [COLS-1:0] rowBus [ROWS];
  logic [COLS-1:0] rowSel;
  logic [COLS-1:0] rowBuf;
  logic [COL_BITS-1:0] colReg;

  // row decoder
  for (genvar r = 0; r < ROWS; r++) begin : gRowDec
    assign rowHit[r] = (rowAddr == ROW_BITS'(r));
  end

  // column demultiplexer
  for (genvar c = 0; c < COLS; c++) begin : gColDec
    assign colHit[c] = (colAddr == COL_BITS'(c));
  end

  // storage rows: only the enabled row, only the steered column
  for (genvar r = 0; r < ROWS; r++) begin : gRow
    logic [COLS-1:0] rowQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rowQ <= '0;
      else if (strobe.storeBit && rowHit[r])
        rowQ <= (rowQ & ~colHit) | (colHit & {COLS{dataIn}});
    end
    assign rowBus[r] = rowQ;
  end

  // whole-row read path into the row buffer
  assign rowSel = rowBus[rowAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowBuf <= '0;
      colReg <= '0;
    end else if (strobe.fetchRow) begin
      rowBuf <= rowSel;
      colReg <= colAddr;
    end
  end

  // column multiplexer
  assign dataOut = rowBuf[colReg];
endmodule

// File: rtl/bitram_rowcol.sv
module bitram_rowcol
  import bitram_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  input  logic                         chipSelN,
  input  logic                         writeEnN,
  input  logic                         dataIn,
  output logic                         dataOut,
  output logic                         dataOutEn
);
  ramStrobe_t strobe;

  bitram_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chipSelN  (chipSelN),
    .writeEnN  (writeEnN),
    .strobe    (strobe),
    .readValid (dataOutEn)
  );

  bitram_array #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS)
  ) u_array (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rowAddr (addr[ROW_BITS+COL_BITS-1:COL_BITS]),
    .colAddr (addr[COL_BITS-1:0]),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );
endmodule

// File: rtl/bitram_checker.sv
module bitram_checker #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [ROW_BITS+COL_BITS-1:0] addr,
  input logic                         chipSelN,
  input logic                         writeEnN,
  input logic                         dataIn,
  input logic                         dataOut,
  input logic                         dataOutEn
);
  // R4: enable only after a sampled selected read
  a_r4_en_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> $past(!chipSelN && writeEnN));

  // R4 / R3: a selected read always raises the enable next cycle
  a_r4_read_raises_en: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && writeEnN) |=> dataOutEn);

  // R5: deselected cycle drives nothing and leaves dataOut alone
  a_r5_deselect_holds: assert property (@(posedge clk) disable iff (!rstN)
    chipSelN |=> (!dataOutEn && $stable(dataOut)));

  // R7: a write cycle does not disturb the read path
  a_r7_write_holds_out: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && !writeEnN) |=> (!dataOutEn && $stable(dataOut)));

  // R3: driven data is always a defined level
  a_r3_out_known: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> !$isunknown(dataOut));
endmodule

bind bitram_rowcol bitram_checker #(
  .ROW_BITS (ROW_BITS),
  .COL_BITS (COL_BITS)
) u_chk (.*);

// File: tb/tb_bitram_rowcol.sv
module tb_bitram_rowcol;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_BITS = 3;
  localparam int COL_BITS = 3;
  localparam int AW = ROW_BITS + COL_BITS;
  localparam int CELLS = 1 << AW;

  typedef struct packed {
    logic          csN;
    logic          weN;
    logic [AW-1:0] adr;
    logic          din;
    logic          expEn;
    logic          expOut;
    logic [3:0]    req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 6'd9,  1'b1, 1'b0, 1'b0, 4'd2}, // R2 write row1 col1
    '{1'b0, 1'b0, 6'd63, 1'b1, 1'b0, 1'b0, 4'd7}, // R7 write, output held
    '{1'b0, 1'b1, 6'd9,  1'b0, 1'b1, 1'b1, 4'd3}, // R3 read back
    '{1'b0, 1'b1, 6'd8,  1'b0, 1'b1, 1'b0, 4'd1}, // R1 same row, other column
    '{1'b0, 1'b1, 6'd17, 1'b0, 1'b1, 1'b0, 4'd1}, // R1 same column, other row
    '{1'b0, 1'b1, 6'd63, 1'b0, 1'b1, 1'b1, 4'd8}, // R8 consecutive read
    '{1'b1, 1'b0, 6'd0,  1'b1, 1'b0, 1'b1, 4'd5}, // R5 deselected write ignored
    '{1'b0, 1'b1, 6'd0,  1'b0, 1'b1, 1'b0, 4'd5}, // R5 cell 0 still clear
    '{1'b0, 1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 4'd7}, // R7 write, output held
    '{1'b0, 1'b1, 6'd0,  1'b0, 1'b1, 1'b1, 4'd9}, // R9 read right after write
    '{1'b0, 1'b0, 6'd9,  1'b0, 1'b0, 1'b1, 4'd2}, // R2 overwrite with 0
    '{1'b0, 1'b1, 6'd9,  1'b0, 1'b1, 1'b0, 4'd9}, // R9 new value visible
    '{1'b1, 1'b1, 6'd63, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 deselected read, no enable
    '{1'b0, 1'b1, 6'd56, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 enable on selected read
    '{1'b0, 1'b0, 6'd56, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 write row7 col0
    '{1'b0, 1'b1, 6'd56, 1'b0, 1'b1, 1'b1, 4'd3}  // R3 read it
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          chipSelN = 1'b1;
  logic          writeEnN = 1'b1;
  logic          dataIn = 1'b0;
  logic          dataOut;
  logic          dataOutEn;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitram_rowcol #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .chipSelN(chipSelN),
    .writeEnN(writeEnN), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutEn(dataOutEn)
  );

  task automatic check(input string tag, input logic gotEn, input logic gotOut,
                       input logic expEn, input logic expOut);
    checks++;
    if (gotEn !== expEn || gotOut !== expOut) begin
      fails++;
      $display("FAIL %s: got en=%b out=%b, expected en=%b out=%b",
               tag, gotEn, gotOut, expEn, expOut);
    end
  endtask

  // drive one cycle at the falling edge, sample after the next rising edge
  task automatic cycle(input logic csN, input logic weN, input logic [AW-1:0] a,
                       input logic d);
    chipSelN = csN; writeEnN = weN; addr = a; dataIn = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic pattern(input int a);
    return logic'(((a >> COL_BITS) ^ a ^ (a >> 4)) & 1);
  endfunction

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R6: reset state at the ports
    check("R6 reset outputs", dataOutEn, dataOut, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R6 / R8: every cell reads 0 after reset, back-to-back reads
    for (int a = 0; a < CELLS; a++) begin
      cycle(1'b0, 1'b1, AW'(a), 1'b0);
      check($sformatf("R6 R8 cleared cell %0d", a), dataOutEn, dataOut, 1'b1, 1'b0);
    end

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      cycle(VECS[i].csN, VECS[i].weN, VECS[i].adr, VECS[i].din);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            dataOutEn, dataOut, VECS[i].expEn, VECS[i].expOut);
    end

    // R1 / R2: fill every cell with a distinct-looking pattern, read all back
    for (int a = 0; a < CELLS; a++) cycle(1'b0, 1'b0, AW'(a), pattern(a));
    for (int a = 0; a < CELLS; a++) begin
      cycle(1'b0, 1'b1, AW'(a), 1'b0);
      check($sformatf("R1 R8 pattern cell %0d", a), dataOutEn, dataOut, 1'b1, pattern(a));
    end

    // R5: deselected writes of inverted data change nothing
    for (int a = 0; a < CELLS; a++) cycle(1'b1, 1'b0, AW'(a), ~pattern(a));
    for (int a = 0; a < CELLS; a += 7) begin
      cycle(1'b0, 1'b1, AW'(a), 1'b0);
      check($sformatf("R5 deselect kept cell %0d", a), dataOutEn, dataOut, 1'b1, pattern(a));
    end

    // R2: single write touches one cell only (row 3, col 5 = 29)
    cycle(1'b0, 1'b0, AW'(29), ~pattern(29));
    for (int a = 24; a < 40; a++) begin
      cycle(1'b0, 1'b1, AW'(a), 1'b0);
      check($sformatf("R2 isolation cell %0d", a), dataOutEn, dataOut, 1'b1,
            (a == 29) ? ~pattern(29) : pattern(a));
    end

    // R6: reset in the middle of a run clears the array
    cycle(1'b0, 1'b1, AW'(63), 1'b0);
    rstN = 1'b0;
    #1;
    check("R6 mid-run reset outputs", dataOutEn, dataOut, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < CELLS; a += 9) begin
      cycle(1'b0, 1'b1, AW'(a), 1'b0);
      check($sformatf("R6 cleared after reset cell %0d", a), dataOutEn, dataOut, 1'b1, 1'b0);
    end

    cycle(1'b1, 1'b1, '0, 1'b0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule